// File: doc/BRIEF.md
# Set-Associative Cache with Way Locking

The block is a write-back, set-associative cache between a processor-side word port and a next-level memory port that moves whole lines. It takes one request at a time over a valid/ready handshake. On a read or write hit it answers from its own storage. On a miss it picks a victim way. If the victim line is dirty it first writes that line out, then reads the missing line, installs it and answers.

Software can pin part of the cache by setting a count of locked ways. The locked ways are always the lowest-numbered ones. A preload request loads the line at a given address into one chosen locked way. Replacement never chooses a locked way, so a preloaded line stays resident while its way remains locked. Victims among the unlocked ways come from a 16-bit pseudo-random generator. Two 32-bit counters record hits and misses so that a test or a performance monitor can watch the cache behave.

With the default parameters the cache has 8 sets, 16 ways and lines of 4 words of 32 bits (16 bytes). Word address bits [1:0] select the word within a line, bits [4:2] select the set, and the remaining upper bits form the tag.

Top module: `wl_cache`

## Requirements
- R1: A read returns the most recent value written to that word address, whether the line is resident, has been evicted, or has been written back.
- R2: With a memory port that is always ready and answers a line read on the cycle after accepting it, response latency is counted in rising edges after the edge that accepts the request. A hit responds after 1 edge, a miss with a clean or invalid victim after 3 edges, and a miss with a dirty victim after 4 edges.
- R3: On a miss, an invalid unlocked way is chosen ahead of any random victim, and the lowest-numbered such way wins. As a result, a set accepts as many distinct lines as it has unlocked ways without evicting any of them.
- R4: A dirty victim is written to the memory port as a full line at its own line address before the read of the new line is issued.
- R5: The victim on a miss is never a locked way. Among unlocked ways `n..WAYS-1`, where n is the lock count, the victim is `n + (lfsr mod (WAYS-n))`. The lfsr is a 16-bit Galois generator with feedback mask 0xB400, seeded with 0xACE1, and it advances once per counted miss.
- R6: The effective lock count is `cfg_lock_ways` clamped to WAYS/2. The locked ways are ways 0 up to n-1.
- R7: A preload whose way index is below the effective lock count, and whose address is not already resident, loads that line into that way as valid and clean. A preload with any other way index, or one whose address is already resident, changes no cached state. Preloads always produce one response and never change either counter.
- R8: `hit_count` and `miss_count` are 0 after reset. Each read or write adds exactly 1 to one of the two counters. Each counter saturates at 2^32-1.
- R9: Only one request is outstanding at a time. `req_ready` is high only while the cache is idle, and it is low in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_lock_ways | input | 5 | Requested number of locked ways |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_preload | input | 1 | 1 = preload the line of req_addr into way req_way |
| req_way | input | 4 | Target way for a preload |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid for reads |
| mem_req_valid | output | 1 | Line request to the next level |
| mem_req_ready | input | 1 | Next level accepts the line request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 14 | Line address |
| mem_req_wdata | output | 128 | Line data for a write-back, word 0 in the low bits |
| mem_rsp_valid | input | 1 | Line read data present |
| mem_rsp_rdata | input | 128 | Line read data, word 0 in the low bits |
| hit_count | output | 32 | Saturating count of hits |
| miss_count | output | 32 | Saturating count of misses |

## Verification
The assertions assume the following about the inputs:
- `cfg_lock_ways` stays steady while a request is in flight.
- `mem_rsp_valid` is raised only while the cache waits for a line read.
- A preload never targets a line that is already cached in a different way.

The bench changes the lock count only between completed requests. Its memory model answers only reads it has accepted. Each preload is issued either right after reset or to a fresh address. The random traffic mixes reads and writes over 256 lines, which is 32 lines per set against 16 ways, so evictions and write-backs happen often while the locked lines are exercised.

// File: rtl/wl_cache_pkg.sv
package wl_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_WAIT
  } wl_state_e;

  // 16-bit Galois generator step, feedback mask 0xB400
  function automatic logic [15:0] lfsr16_next(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

  // effective lock count: at most half the ways
  function automatic int unsigned lock_clamp(input int unsigned req, input int unsigned ways);
    return (req > ways / 2) ? ways / 2 : req;
  endfunction

  // map a random value onto the unlocked ways [lock .. ways-1]
  function automatic int unsigned pick_unlocked(input int unsigned rnd, input int unsigned lock,
                                                input int unsigned ways);
    return lock + (rnd % (ways - lock));
  endfunction

endpackage

// File: rtl/wl_sat_ctr.sv
module wl_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  q <= '0;
    else if (inc && q != MAXV)   q <= q + 1'b1;
  end

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAXV) |=> (q == MAXV));
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && q != MAXV) |=> (q == $past(q) + 1'b1));
endmodule

// File: rtl/wl_tag_match.sv
module wl_tag_match #(
  parameter int WAYS  = 16,
  parameter int TAG_W = 11,
  parameter int WAY_W = 4
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valid,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            match,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == tag);
  end

  always_comb begin
    hit = |match;
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wl_victim_pick.sv
module wl_victim_pick
  import wl_cache_pkg::*;
#(
  parameter int WAYS   = 16,
  parameter int WAY_W  = 4,
  parameter int LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [LOCK_W-1:0] lock_n,
  input  logic [WAYS-1:0]   valid_row,
  output logic [WAY_W-1:0]  victim
);
  logic [15:0]      lfsr_q;
  logic             free_found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] rnd_way;

  always_ff @(posedge clk) begin
    if (!rst_n)     lfsr_q <= 16'hACE1;
    else if (step)  lfsr_q <= lfsr16_next(lfsr_q);
  end

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (w >= int'(lock_n) && !valid_row[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
    rnd_way = WAY_W'(pick_unlocked(int'(lfsr_q), int'(lock_n), WAYS));
    victim  = free_found ? free_way : rnd_way;
  end

  a_r3_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (step && free_found) |-> !valid_row[victim]);
  a_r5_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ({1'b0, victim} >= lock_n));
endmodule

// File: rtl/wl_cache.sv
module wl_cache
  import wl_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 8,
  parameter int WAYS       = 16,
  parameter int LINE_WORDS = 4,
  parameter int CNT_W      = 32,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int SET_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int LOCK_W    = WAY_W + 1,
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOCK_W-1:0]  cfg_lock_ways,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_preload,
  input  logic [WAY_W-1:0]   req_way,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [LADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [LINE_W-1:0]  mem_rsp_rdata,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  // storage
  logic [DATA_W-1:0]                     data_q [SETS][WAYS][LINE_WORDS];
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0]             valid_q;
  logic [SETS-1:0][WAYS-1:0]             dirty_q;

  // request held during service
  wl_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic              pre_q;
  logic [WAY_W-1:0]  way_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  vic_q;

  logic [OFF_W-1:0]  off_r;
  logic [SET_W-1:0]  set_r;
  logic [TAG_W-1:0]  tag_r;
  assign off_r = addr_q[OFF_W-1:0];
  assign set_r = addr_q[OFF_W +: SET_W];
  assign tag_r = addr_q[ADDR_W-1 -: TAG_W];

  logic [LOCK_W-1:0] lock_n;
  assign lock_n = LOCK_W'(lock_clamp(int'(cfg_lock_ways), WAYS));

  // lookup
  logic [WAYS-1:0]  match_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  wl_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .tags(tag_q[set_r]), .valid(valid_q[set_r]), .tag(tag_r),
    .match(match_vec), .hit(hit), .way(hit_way)
  );

  // named events
  logic             in_look, pre_ok, ev_hit, ev_miss, ev_prefill, go_alloc, alloc_dirty;
  logic [WAY_W-1:0] vic_way, alloc_way;
  assign in_look     = (st_q == ST_LOOK);
  assign pre_ok      = ({1'b0, way_q} < lock_n);
  assign ev_hit      = in_look && !pre_q && hit;
  assign ev_miss     = in_look && !pre_q && !hit;
  assign ev_prefill  = in_look && pre_q && !hit && pre_ok;
  assign go_alloc    = ev_miss || ev_prefill;
  assign alloc_way   = pre_q ? way_q : vic_way;
  assign alloc_dirty = valid_q[set_r][alloc_way] && dirty_q[set_r][alloc_way];

  wl_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W), .LOCK_W(LOCK_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .step(ev_miss), .lock_n(lock_n),
    .valid_row(valid_q[set_r]), .victim(vic_way)
  );

  wl_sat_ctr #(.W(CNT_W)) u_hits   (.clk(clk), .rst_n(rst_n), .inc(ev_hit),  .q(hit_count));
  wl_sat_ctr #(.W(CNT_W)) u_misses (.clk(clk), .rst_n(rst_n), .inc(ev_miss), .q(miss_count));

  // memory port
  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_WB) || (st_q == ST_FILL);
  assign mem_req_write = (st_q == ST_WB);
  assign mem_req_addr  = (st_q == ST_WB) ? {tag_q[set_r][vic_q], set_r} : addr_q[ADDR_W-1:OFF_W];

  always_comb begin
    for (int w = 0; w < LINE_WORDS; w++) begin
      mem_req_wdata[w*DATA_W +: DATA_W] = data_q[set_r][vic_q][w];
    end
  end

  logic fill_done;
  assign fill_done = (st_q == ST_WAIT) && mem_rsp_valid;

  // control and status bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      vic_q     <= '0;
      valid_q   <= '0;
      dirty_q   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid) st_q <= ST_LOOK;
        ST_LOOK: begin
          if (ev_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= data_q[set_r][hit_way][off_r];
            if (wr_q) dirty_q[set_r][hit_way] <= 1'b1;
            st_q <= ST_IDLE;
          end else if (go_alloc) begin
            vic_q <= alloc_way;
            st_q  <= alloc_dirty ? ST_WB : ST_FILL;
          end else begin
            rsp_valid <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        ST_WB:   if (mem_req_ready) st_q <= ST_FILL;
        ST_FILL: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          valid_q[set_r][vic_q] <= 1'b1;
          dirty_q[set_r][vic_q] <= wr_q;
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rsp_rdata[int'(off_r)*DATA_W +: DATA_W];
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // request capture, tags and data
  always_ff @(posedge clk) begin
    if (st_q == ST_IDLE && req_valid) begin
      addr_q  <= req_addr;
      wr_q    <= req_write && !req_preload;
      pre_q   <= req_preload;
      way_q   <= req_way;
      wdata_q <= req_wdata;
    end
    if (ev_hit && wr_q) data_q[set_r][hit_way][off_r] <= wdata_q;
    if (fill_done) begin
      tag_q[set_r][vic_q] <= tag_r;
      for (int w = 0; w < LINE_WORDS; w++) begin
        data_q[set_r][vic_q][w] <= (wr_q && w == int'(off_r)) ? wdata_q
                                   : mem_rsp_rdata[w*DATA_W +: DATA_W];
      end
    end
  end

  // assertions
  a_r1_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
    in_look |-> $onehot0(match_vec));
  a_r2_hit_answers: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> rsp_valid);
  a_r4_clean_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write && $past(st_q == ST_LOOK))
      |-> !(valid_q[set_r][vic_q] && dirty_q[set_r][vic_q]));
  a_r5_alloc_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |-> ({1'b0, vic_way} >= lock_n));
  a_r7_preload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_look && pre_q) |=> ($stable(hit_count) && $stable(miss_count)));
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/wl_cache_bench.sv
module wl_cache_bench;
  localparam int DW = 32;
  localparam int LW = 4;
  localparam int NWORDS = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   cfg_lock_ways = '0;
  logic         req_valid = 1'b0, req_ready, req_write = 1'b0, req_preload = 1'b0;
  logic [3:0]   req_way = '0;
  logic [15:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid, mem_req_write;
  logic         mem_req_ready = 1'b1;
  logic [13:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_rdata = '0;
  logic [31:0]  hit_count, miss_count;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wl_cache u_wl_cache (
    .clk(clk), .rst_n(rst_n), .cfg_lock_ways(cfg_lock_ways),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_preload(req_preload), .req_way(req_way), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .hit_count(hit_count), .miss_count(miss_count)
  );

  // next-level memory model and expected contents
  logic [31:0] mem_words [NWORDS];
  logic [31:0] exp_words [NWORDS];
  logic        pend = 1'b0;
  logic [7:0]  pend_line = '0;

  function automatic logic [31:0] init_word(input int a);
    return 32'hC0DE0000 ^ (a * 32'h00010003);
  endfunction

  always @(negedge clk) begin
    if (pend) begin
      mem_rsp_valid = 1'b1;
      for (int w = 0; w < LW; w++) mem_rsp_rdata[w*DW +: DW] = mem_words[{pend_line, 2'(w)}];
      pend = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (mem_req_valid) begin
      if (mem_req_write) begin
        for (int w = 0; w < LW; w++) mem_words[{mem_req_addr[7:0], 2'(w)}] = mem_req_wdata[w*DW +: DW];
      end else begin
        pend      = 1'b1;
        pend_line = mem_req_addr[7:0];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < NWORDS; a++) exp_words[a] = mem_words[a];
  endtask

  // one request; lat = rising edges from acceptance to response
  task automatic issue(input logic pre, input logic wr, input int addr, input logic [31:0] wd,
                       input int way, output logic [31:0] rd, output int lat, output logic rdy_after);
    @(negedge clk);
    req_valid = 1'b1; req_preload = pre; req_write = wr;
    req_addr = 16'(addr); req_wdata = wd; req_way = 4'(way);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    rdy_after = req_ready;
    lat = 0;
    while (!rsp_valid) begin
      @(posedge clk);
      #1;
      lat++;
    end
    rd = rsp_rdata;
    if (wr && !pre) exp_words[addr] = wd;
  endtask

  int          lat;
  logic [31:0] rd;
  logic        rdy;
  logic [31:0] h0, m0;

  // read with data check; reports whether it counted as a hit
  task automatic rd_chk(input int addr, input string tag, output bit was_hit);
    logic [31:0] hb;
    hb = hit_count;
    issue(1'b0, 1'b0, addr, 32'h0, 0, rd, lat, rdy);
    chk(rd == exp_words[addr], tag, rd, exp_words[addr]);
    was_hit = (hit_count == hb + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit hb;
    int ops;
    void'($urandom(32'd4242));
    for (int a = 0; a < NWORDS; a++) mem_words[a] = init_word(a);
    do_reset();

    // R8: reset state
    chk(hit_count == 0, "R8 hit_count after reset", hit_count, 0);
    chk(miss_count == 0, "R8 miss_count after reset", miss_count, 0);
    chk(rsp_valid == 1'b0, "R8 rsp_valid after reset", rsp_valid, 0);

    // R3: 16 distinct lines of set 0 all stay resident
    cfg_lock_ways = 5'd0;
    issue(1'b0, 1'b0, 0, 32'h0, 0, rd, lat, rdy);
    chk(lat == 3, "R2 clean miss latency", lat, 3);
    chk(rdy == 1'b0, "R9 not ready while busy", rdy, 0);
    chk(rd == exp_words[0], "R1 first read data", rd, exp_words[0]);
    for (int i = 1; i < 16; i++) issue(1'b0, 1'b0, i * 32, 32'h0, 0, rd, lat, rdy);
    chk(miss_count == 16, "R8 misses after fill", miss_count, 16);
    h0 = hit_count;
    for (int i = 0; i < 16; i++) begin
      issue(1'b0, 1'b0, i * 32 + 1, 32'h0, 0, rd, lat, rdy);
      if (i == 0) chk(lat == 1, "R2 hit latency", lat, 1);
    end
    chk(hit_count == h0 + 16, "R3 all lines resident", hit_count, h0 + 16);
    chk(miss_count == 16, "R3 no extra misses", miss_count, 16);

    // R4: dirty line in way 0 written back when a preload targets way 0
    do_reset();
    cfg_lock_ways = 5'd0;
    issue(1'b0, 1'b1, 2, 32'hDEADBEEF, 0, rd, lat, rdy);
    chk(lat == 3, "R2 write miss latency", lat, 3);
    cfg_lock_ways = 5'd1;
    h0 = hit_count; m0 = miss_count;
    issue(1'b1, 1'b0, 32, 32'h0, 0, rd, lat, rdy);
    chk(lat == 4, "R4 dirty victim latency", lat, 4);
    chk(mem_words[2] == 32'hDEADBEEF, "R4 write-back data", mem_words[2], 32'hDEADBEEF);
    chk(hit_count == h0 && miss_count == m0, "R7 preload leaves counters", hit_count + miss_count, h0 + m0);
    rd_chk(33, "R1 preloaded data", hb);
    chk(hb, "R7 preloaded line hits", hb, 1);
    rd_chk(2, "R1 data after write-back", hb);
    chk(!hb, "R4 evicted line misses", hb, 0);

    // R7: preload to an unlocked way is dropped
    issue(1'b1, 1'b0, 64, 32'h0, 5, rd, lat, rdy);
    chk(lat == 1, "R7 dropped preload latency", lat, 1);
    rd_chk(64, "R1 read after dropped preload", hb);
    chk(!hb, "R7 dropped preload not resident", hb, 0);

    // R6: lock request 15 clamps to 8
    cfg_lock_ways = 5'd15;
    issue(1'b1, 1'b0, 96, 32'h0, 9, rd, lat, rdy);
    rd_chk(96, "R1 read clamp case", hb);
    chk(!hb, "R6 way 9 not locked", hb, 0);
    issue(1'b1, 1'b0, 128, 32'h0, 7, rd, lat, rdy);
    rd_chk(128, "R1 read way 7 case", hb);
    chk(hb, "R6 way 7 locked", hb, 1);

    // R5/R1/R8: locked lines survive random traffic
    do_reset();
    cfg_lock_ways = 5'd4;
    for (int k = 0; k < 4; k++) issue(1'b1, 1'b0, (8 + k) * 32, 32'h0, k, rd, lat, rdy);
    h0 = hit_count; m0 = miss_count;
    ops = 3000;
    for (int n = 0; n < ops; n++) begin
      int a;
      logic w;
      logic [31:0] d;
      a = int'($urandom_range(0, NWORDS - 1));
      w = ($urandom % 10) < 4;
      d = $urandom;
      issue(1'b0, w, a, d, 0, rd, lat, rdy);
      if (!w) chk(rd == exp_words[a], "R1 random read data", rd, exp_words[a]);
    end
    chk((hit_count - h0) + (miss_count - m0) == ops, "R8 one count per access",
        (hit_count - h0) + (miss_count - m0), ops);
    for (int k = 0; k < 4; k++) begin
      rd_chk((8 + k) * 32 + 3, "R1 locked line data", hb);
      chk(hb, "R5 locked line still resident", hb, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule